// File: doc/BRIEF.md
# Multi-Mode Bridge PWM Generator

This block produces a pulse-width modulated waveform with 10-bit duty resolution and steers it onto four drive lines, A to D. The waveform can drive a single line, a complementary pair with a dead gap between the two phases, or a four-switch bridge that runs in either direction. A period-start strobe marks the first clock of every period, so a controller can line up its duty and mode updates with the waveform.

The time base is an 8-bit period counter. A 2-bit sub-count sits below it and divides the clock by four, so one period lasts (period + 1) x 4 clocks. The duty value is compared with the combined 10-bit time base. The duty value, the mode and the direction are all sampled at a period boundary, so a write in the middle of a period never changes the pulse that is already running. After enable, the lines stay inactive until a new period begins.

Top module: `bpwm_bridge`

## Requirements
- R1: One period lasts (period + 1) x 4 clock cycles. While enabled, `periodStart` is high for exactly one clock at the first cycle of each period and is low otherwise.
- R2: In single mode, with 0 < duty < (period + 1) x 4, output A is active for exactly `duty` clocks in every period.
- R3: A duty of zero keeps the modulated output inactive for the whole period. A duty at or above (period + 1) x 4 keeps it active for the whole period.
- R4: The duty value is sampled only at a period boundary. A change written during a period alters the pulse only from the next period onward.
- R5: While `enable` is low, all four lines are inactive and `periodStart` stays low. After `enable` rises, no line becomes active before the first `periodStart`, and the first pulse has its full length.
- R6: Mode encodings: 2'b00 single, 2'b01 half-bridge, 2'b10 and 2'b11 full-bridge. In single mode only A (bit 0 of `drive`) carries the waveform, and B, C and D (bits 1, 2 and 3) stay inactive.
- R7: In half-bridge mode, A carries the waveform and B its complement. Each line turns active only `deadBand` clocks after the other line turns off, and A and B are never active together. Per period, A is active for duty - deadBand clocks and B for (period + 1) x 4 - duty - deadBand clocks.
- R8: In full-bridge mode with `reverse` = 0, A is held active, D carries the waveform, and B and C are inactive.
- R9: In full-bridge mode with `reverse` = 1, C is held active, B carries the waveform, and A and D are inactive.
- R10: Setting `polarity[i]` to 1 makes line i active-low. A line that is inactive then drives 1.
- R11: A change to `mode` or `reverse` takes effect only at the next period boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Runs the generator; when low, all lines are inactive |
| mode | input | 2 | Output steering mode (see R6) |
| reverse | input | 1 | Full-bridge direction: 0 forward, 1 reverse |
| polarity | input | 4 | Per-line polarity: 1 means active-low |
| period | input | PER_W (8) | Period register for the upper counter |
| duty | input | PER_W+SUB_W (10) | Pending duty value in clocks |
| deadBand | input | DB_W (4) | Dead gap in clocks for half-bridge mode |
| drive | output | 4 | Drive lines; bit 0 is A, bit 3 is D |
| periodStart | output | 1 | One-clock strobe at each period start |

## Verification
The bench builds the block with its default widths (8-bit period, 2-bit sub-count, 4-bit dead band) and programs a period of 4, which gives 20-clock periods. With such short periods, duty values at zero, inside the period, exactly equal to the period length and at the 10-bit maximum are all quick to reach. The same holds for dead gaps that take a visible share of each phase. Mode, direction and duty writes are placed a few clocks into a period, so the deferral to the next boundary shows directly in the per-period counts of active cycles on each line.

// File: rtl/bpwm_pkg.sv
package bpwm_pkg;

  typedef enum logic [1:0] {
    MODE_SINGLE  = 2'b00,
    MODE_HALF    = 2'b01,
    MODE_FULL    = 2'b10,
    MODE_FULL_B  = 2'b11
  } bpwm_mode_e;

  // Strobes passed from control to datapath
  typedef struct packed {
    logic load;    // period boundary: latch pending duty
    logic active;  // generator running, lines may be driven
  } bpwm_strobe_t;

endpackage

// File: rtl/bpwm_ctrl.sv
module bpwm_ctrl
  import bpwm_pkg::*;
#(
  parameter int PER_W = 8,
  parameter int SUB_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [1:0]       modeIn,
  input  logic             reverseIn,
  input  logic [PER_W-1:0] period,
  output logic [PER_W-1:0] perCnt,
  output logic [SUB_W-1:0] subCnt,
  output bpwm_strobe_t     strb,
  output bpwm_mode_e       activeMode,
  output logic             activeRev,
  output logic             periodStart
);

  localparam logic [SUB_W-1:0] SUB_LAST = {SUB_W{1'b1}};

  logic subLast;
  logic periodEnd;
  logic running;

  assign subLast   = (subCnt == SUB_LAST);
  // >= also recovers when the period register is lowered mid-period
  assign periodEnd = subLast && (perCnt >= period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      subCnt <= '0;
      perCnt <= '0;
    end else begin
      subCnt <= subCnt + 1'b1;
      if (subLast) begin
        if (periodEnd) perCnt <= '0;
        else           perCnt <= perCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running     <= 1'b0;
      periodStart <= 1'b0;
      activeMode  <= MODE_SINGLE;
      activeRev   <= 1'b0;
    end else begin
      periodStart <= enable && periodEnd;
      if (!enable)        running <= 1'b0;
      else if (periodEnd) running <= 1'b1;
      if (periodEnd) begin
        activeMode <= bpwm_mode_e'(modeIn);
        activeRev  <= reverseIn;
      end
    end
  end

  assign strb.load   = periodEnd;
  assign strb.active = running;

  a_r1_strobe_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    periodStart |=> !periodStart);

  a_r1_upper_steps_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !subLast |=> $stable(perCnt));

  a_r5_start_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> periodStart);

  a_r11_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !periodEnd |=> ($stable(activeMode) && $stable(activeRev)));

endmodule

// File: rtl/bpwm_datapath.sv
module bpwm_datapath
  import bpwm_pkg::*;
#(
  parameter int PER_W = 8,
  parameter int SUB_W = 2,
  parameter int DB_W  = 4,
  parameter int LINES = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  bpwm_strobe_t           strb,
  input  logic [PER_W-1:0]       perCnt,
  input  logic [SUB_W-1:0]       subCnt,
  input  logic [PER_W+SUB_W-1:0] duty,
  input  logic [DB_W-1:0]        deadBand,
  input  bpwm_mode_e             activeMode,
  input  logic                   activeRev,
  input  logic [LINES-1:0]       polarity,
  output logic [LINES-1:0]       drive
);

  localparam int DUTY_W = PER_W + SUB_W;

  logic [DUTY_W-1:0] dutyShadow;
  logic [DUTY_W-1:0] timeBase;
  logic              pwmQ;
  logic              hbRaw;
  logic [DB_W-1:0]   dbCnt;
  logic              dbIdle;
  logic [LINES-1:0]  drv;

  assign timeBase = {perCnt, subCnt};
  assign dbIdle   = (dbCnt == '0);

  // Shadow duty register, refreshed only at a period boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         dutyShadow <= '0;
    else if (strb.load) dutyShadow <= duty;
  end

  // Comparator: active from period start until the time base reaches duty
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwmQ <= 1'b0;
    else        pwmQ <= strb.active && (timeBase < dutyShadow);
  end

  // Dead-band timer restarts on every waveform edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hbRaw <= 1'b0;
      dbCnt <= '0;
    end else begin
      hbRaw <= pwmQ;
      if (pwmQ != hbRaw) dbCnt <= deadBand;
      else if (!dbIdle)  dbCnt <= dbCnt - 1'b1;
    end
  end

  // Output steering
  always_comb begin
    drv = '0;
    if (strb.active) begin
      unique case (activeMode)
        MODE_SINGLE: drv[0] = hbRaw;
        MODE_HALF: begin
          drv[0] = hbRaw && dbIdle;
          drv[1] = !hbRaw && dbIdle;
        end
        default: begin
          if (!activeRev) begin
            drv[0] = 1'b1;
            drv[3] = hbRaw;
          end else begin
            drv[2] = 1'b1;
            drv[1] = hbRaw;
          end
        end
      endcase
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < LINES; gi++) begin : g_pol
      assign drive[gi] = drv[gi] ^ polarity[gi];
    end
  endgenerate

  a_r4_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.load |=> $stable(dutyShadow));

  a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    (activeMode == MODE_HALF) |-> !(drv[0] && drv[1]));

  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.active |-> (drv == '0));

  a_r6_single_only_a: assert property (@(posedge clk) disable iff (!rst_n)
    (activeMode == MODE_SINGLE) |-> (drv[LINES-1:1] == '0));

  a_r3_zero_duty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (dutyShadow == '0) |=> !pwmQ);

endmodule

// File: rtl/bpwm_bridge.sv
module bpwm_bridge
  import bpwm_pkg::*;
#(
  parameter int PER_W = 8,
  parameter int SUB_W = 2,
  parameter int DB_W  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   enable,
  input  logic [1:0]             mode,
  input  logic                   reverse,
  input  logic [3:0]             polarity,
  input  logic [PER_W-1:0]       period,
  input  logic [PER_W+SUB_W-1:0] duty,
  input  logic [DB_W-1:0]        deadBand,
  output logic [3:0]             drive,
  output logic                   periodStart
);

  logic [PER_W-1:0] perCnt;
  logic [SUB_W-1:0] subCnt;
  bpwm_strobe_t     strb;
  bpwm_mode_e       activeMode;
  logic             activeRev;

  bpwm_ctrl #(.PER_W(PER_W), .SUB_W(SUB_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .modeIn     (mode),
    .reverseIn  (reverse),
    .period     (period),
    .perCnt     (perCnt),
    .subCnt     (subCnt),
    .strb       (strb),
    .activeMode (activeMode),
    .activeRev  (activeRev),
    .periodStart(periodStart)
  );

  bpwm_datapath #(.PER_W(PER_W), .SUB_W(SUB_W), .DB_W(DB_W), .LINES(4)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strb       (strb),
    .perCnt     (perCnt),
    .subCnt     (subCnt),
    .duty       (duty),
    .deadBand   (deadBand),
    .activeMode (activeMode),
    .activeRev  (activeRev),
    .polarity   (polarity),
    .drive      (drive)
  );

endmodule

// File: tb/bpwm_bridge_test.sv
module bpwm_bridge_test;

  localparam int TOTAL = 20;  // (4 + 1) * 4 clocks

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       reverse = 1'b0;
  logic [3:0] polarity = 4'b0000;
  logic [7:0] period = 8'd4;
  logic [9:0] duty = 10'd8;
  logic [3:0] deadBand = 4'd0;
  logic [3:0] drive;
  logic       periodStart;

  int checks = 0;
  int errors = 0;
  int cnt[4];
  int both;
  bit finished = 0;

  always #2 clk = ~clk;

  bpwm_bridge uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode),
    .reverse(reverse), .polarity(polarity), .period(period),
    .duty(duty), .deadBand(deadBand), .drive(drive),
    .periodStart(periodStart)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit isActive(input int i);
    return drive[i] != polarity[i];
  endfunction

  task automatic nextStrobe();
    @(negedge clk);
    while (!periodStart) @(negedge clk);
  endtask

  // Count active cycles per line over one full period starting at a strobe
  task automatic measure();
    nextStrobe();
    for (int k = 0; k < 4; k++) cnt[k] = 0;
    both = 0;
    for (int i = 0; i < TOTAL; i++) begin
      for (int k = 0; k < 4; k++) if (isActive(k)) cnt[k]++;
      if (isActive(0) && isActive(1)) both++;
      @(negedge clk);
    end
  endtask

  task automatic testReset();
    @(negedge clk);
    check(drive == 4'b0000, "R5 reset drive", drive, 0);
    check(periodStart == 1'b0, "R5 reset strobe", periodStart, 0);
  endtask

  task automatic testEnable();
    int early = 0;
    int strobes = 0;
    mode = 2'b00; duty = 10'd8;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (drive != 4'b0000) early++;
      if (periodStart) strobes++;
    end
    check(early == 0, "R5 idle drive while disabled", early, 0);
    check(strobes == 0, "R5 no strobe while disabled", strobes, 0);
    enable = 1'b1;
    early = 0;
    for (int i = 0; i < 40 && !periodStart; i++) begin
      if (isActive(0)) early++;
      @(negedge clk);
    end
    check(early == 0, "R5 no output before period start", early, 0);
    cnt[0] = 0;
    for (int i = 0; i < TOTAL; i++) begin
      if (isActive(0)) cnt[0]++;
      @(negedge clk);
    end
    check(cnt[0] == 8, "R5 first pulse full length", cnt[0], 8);
  endtask

  task automatic testPeriod();
    int gap = 0;
    nextStrobe();
    @(negedge clk);
    check(periodStart == 1'b0, "R1 strobe one clock", periodStart, 0);
    gap = 1;
    while (!periodStart && gap < 100) begin
      @(negedge clk);
      gap++;
    end
    check(gap == TOTAL, "R1 period length", gap, TOTAL);
  endtask

  task automatic testSingle();
    mode = 2'b00; duty = 10'd8;
    nextStrobe();
    measure();
    check(cnt[0] == 8, "R2 single duty 8", cnt[0], 8);
    check(cnt[1] + cnt[2] + cnt[3] == 0, "R6 unused lines idle", cnt[1] + cnt[2] + cnt[3], 0);
    duty = 10'd13;
    nextStrobe();
    measure();
    check(cnt[0] == 13, "R2 single duty 13", cnt[0], 13);
  endtask

  task automatic testDutyEdges();
    duty = 10'd0;
    nextStrobe();
    measure();
    check(cnt[0] == 0, "R3 zero duty", cnt[0], 0);
    duty = 10'd20;
    nextStrobe();
    measure();
    check(cnt[0] == TOTAL, "R3 duty equals period", cnt[0], TOTAL);
    duty = 10'd1023;
    nextStrobe();
    measure();
    check(cnt[0] == TOTAL, "R3 duty maximum", cnt[0], TOTAL);
  endtask

  task automatic testBuffer();
    duty = 10'd8;
    nextStrobe();
    nextStrobe();
    cnt[0] = 0;
    for (int i = 0; i < TOTAL; i++) begin
      if (i == 3) duty = 10'd16;
      if (isActive(0)) cnt[0]++;
      @(negedge clk);
    end
    check(cnt[0] == 8, "R4 mid-period write deferred", cnt[0], 8);
    measure();
    check(cnt[0] == 16, "R4 new duty next period", cnt[0], 16);
  endtask

  task automatic testHalf();
    mode = 2'b01; duty = 10'd8; deadBand = 4'd2;
    nextStrobe();
    measure();
    check(cnt[0] == 6, "R7 half A with gap", cnt[0], 6);
    check(cnt[1] == 10, "R7 half B with gap", cnt[1], 10);
    check(both == 0, "R7 no overlap", both, 0);
    check(cnt[2] + cnt[3] == 0, "R7 C D idle", cnt[2] + cnt[3], 0);
    deadBand = 4'd0;
    nextStrobe();
    measure();
    check(cnt[0] == 8, "R7 half A no gap", cnt[0], 8);
    check(cnt[1] == 12, "R7 half B no gap", cnt[1], 12);
  endtask

  task automatic testFull();
    mode = 2'b10; reverse = 1'b0; duty = 10'd8;
    nextStrobe();
    measure();
    check(cnt[0] == TOTAL, "R8 forward A held", cnt[0], TOTAL);
    check(cnt[3] == 8, "R8 forward D modulated", cnt[3], 8);
    check(cnt[1] + cnt[2] == 0, "R8 forward B C idle", cnt[1] + cnt[2], 0);
    reverse = 1'b1;
    nextStrobe();
    measure();
    check(cnt[2] == TOTAL, "R9 reverse C held", cnt[2], TOTAL);
    check(cnt[1] == 8, "R9 reverse B modulated", cnt[1], 8);
    check(cnt[0] + cnt[3] == 0, "R9 reverse A D idle", cnt[0] + cnt[3], 0);
  endtask

  task automatic testDefer();
    int dAct = 0;
    mode = 2'b00; reverse = 1'b0; duty = 10'd8;
    nextStrobe();
    nextStrobe();
    for (int i = 0; i <= TOTAL; i++) begin
      if (i == 3) mode = 2'b10;
      if (i >= 3 && isActive(3)) dAct++;
      if (i < TOTAL) @(negedge clk);
    end
    check(dAct == 0, "R11 mode change deferred", dAct, 0);
    measure();
    check(cnt[3] == 8, "R11 mode applied at boundary", cnt[3], 8);
  endtask

  task automatic testPolarity();
    mode = 2'b00; polarity = 4'b1111; duty = 10'd8;
    nextStrobe();
    measure();
    check(cnt[0] == 8, "R10 active-low A pulse", cnt[0], 8);
    check(drive[3:1] == 3'b111, "R10 idle lines high", drive[3:1], 7);
    polarity = 4'b0000;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rst_n = 1'b1;
    testEnable();
    testPeriod();
    testSingle();
    testDutyEdges();
    testBuffer();
    testHalf();
    testFull();
    testDefer();
    testPolarity();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule